// File: doc/BRIEF.md
# Configurable Control-Pin Function Decoder

This block turns a handful of general-purpose input pins into the control signals of a multi-output clock generator. Each pin is given one function from a fixed menu through a small map that is written at configuration time. The available functions are a global output enable, four pairwise bank enables, two profile-select bits and a device-reset request. The block drives eight output-enable bits, a 2-bit index that picks the active frequency profile, and a one-cycle reset request.

Every pin passes through a two-flop synchronizer. The enable functions take effect live. The profile-select bits are not followed live: they are sampled only when a device reset happens, which is either the first cycle after the block's own reset or a debounced assertion of the reset-function pin. The map checks each write and refuses placements the menu does not allow. It also flags any map in which two pins carry the same function.

Top module: `ctlpin_decoder`

## Requirements
- R1: After `rst` (synchronous, active high), `oe_o` is 8'hFF, `prof_o` is 0, `rst_req_o`, `map_rej_o` and `cfg_dup_o` are 0, and every pin is unassigned (function code 0).
- R2: A write with `map_we` high stores `map_func` as the function of pin `map_pin`. Function codes are: 0 none, 1 all-outputs enable, 2/3/4/5 bank A/B/C/D enable, 6 select bit 0, 7 select bit 1, 8 reset. The write is rejected and the map left unchanged when the pin index is 5 or more, when the code is 9 or more, or when code 6 or 7 targets pin 3 or 4. `map_rej_o` is high in the cycle after a rejected write and low after an accepted one.
- R3: The all-outputs enable is active low. While its pin is low every output may be enabled, and while its pin is high all eight `oe_o` bits are 0.
- R4: Bank enables are active low. Bank A gates outputs 0/1, B gates 2/3, C gates 4/5 and D gates 6/7. Each `oe_o` bit is the AND of the all-outputs enable and its bank enable.
- R5: An enable function that no pin carries counts as enabled.
- R6: A pin change on an enable function reaches `oe_o` on the third rising clock edge after the change.
- R7: When two or more pins carry the same nonzero function, `cfg_dup_o` is 1 and the lowest-numbered of those pins alone controls the function. Otherwise `cfg_dup_o` is 0.
- R8: The reset function is active low. Once the synchronized pin has been low for 4 consecutive cycles, `rst_req_o` is high for exactly one cycle, on the sixth rising edge after the pin falls. A shorter low produces no pulse, and no second pulse follows until the pin has returned high.
- R9: `prof_o` is loaded from the select code only in the cycle after `rst` is released and on the edge where `rst_req_o` rises. The code is formed with select bit 0 as bit 0 and select bit 1 as bit 1, a pin high reads 1, and an unassigned select bit reads 0. Changing the select pins at any other time leaves `prof_o` unchanged.
- R10: Only profiles 0, 1 and 2 exist, and a select code of 3 loads profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 5 | Raw levels of the assignable pins |
| map_we | input | 1 | Map write strobe |
| map_pin | input | 3 | Pin index for a map write |
| map_func | input | 4 | Function code for a map write |
| map_rej_o | output | 1 | Previous write was rejected |
| cfg_dup_o | output | 1 | A function is placed on more than one pin |
| oe_o | output | 8 | Active-high enable for each clock output |
| prof_o | output | 2 | Active frequency profile index |
| rst_req_o | output | 1 | One-cycle device reset request |

## Verification
The bench sweeps all 32 pin patterns under two maps: one with every enable placed and one with a single bank. A design that swapped bank pairs, inverted the pin polarity, or defaulted an unplaced enable to disabled would produce wrong `oe_o` words. The reset pin is held low for 3, 4 and 12 cycles. A debounce that counted one too few or too many cycles, or that re-fired during a long low, would be caught by counting pulses and checking the edge they fall on. Every select code is latched through a reset pulse, and the select pins are then moved without a reset, which exposes a profile that follows the pins live or passes code 3 through. Rejected placements are checked both by the reject flag and by showing that the old function still controls its outputs. A duplicate placement is checked by showing that the higher-numbered pin has no effect.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;

    localparam int FN_W   = 4;
    localparam int NUM_FN = 9;
    localparam int NUM_BANKS = 4;

    typedef enum logic [FN_W-1:0] {
        FN_NONE   = 4'd0,
        FN_OE_ALL = 4'd1,
        FN_BANK_A = 4'd2,
        FN_BANK_B = 4'd3,
        FN_BANK_C = 4'd4,
        FN_BANK_D = 4'd5,
        FN_SEL0   = 4'd6,
        FN_SEL1   = 4'd7,
        FN_DEVRST = 4'd8
    } pin_fn_e;

    typedef logic [1:0] prof_t;

    // Routing of one function: whether a pin carries it and which one.
    typedef struct packed {
        logic       present;
        logic [7:0] pin;
    } fn_route_t;

    // A placement is legal when pin and code are in range and the
    // select bits sit on one of the low select-capable pins.
    function automatic logic place_ok(input int pin, input logic [FN_W-1:0] code,
                                      input int num_pins, input int sel_pins);
        logic ok;
        ok = 1'b1;
        if (pin >= num_pins) ok = 1'b0;
        if (int'(code) >= NUM_FN) ok = 1'b0;
        if ((code == FN_SEL0 || code == FN_SEL1) && pin >= sel_pins) ok = 1'b0;
        return ok;
    endfunction

    function automatic prof_t prof_decode(input logic [1:0] code, input int num_prof);
        return (int'(code) < num_prof) ? code : 2'd0;
    endfunction

endpackage

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1_q;
        logic s2_q;
        always_ff @(posedge clk) begin
            s1_q <= d_i[b];
            s2_q <= s1_q;
        end
        assign q_o[b] = s2_q;
    end
endmodule

// File: rtl/ctlpin_map.sv
module ctlpin_map
    import ctlpin_pkg::*;
#(
    parameter int NUM_PINS = 5,
    parameter int SEL_PINS = 3,
    parameter int PIN_IW   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  logic [PIN_IW-1:0]      pin_i,
    input  logic [FN_W-1:0]        func_i,
    output logic                   rej_o,
    output logic                   dup_o,
    output fn_route_t [NUM_FN-1:0] route_o
);
    logic [FN_W-1:0] map_q [NUM_PINS];
    logic            legal;
    logic [NUM_FN-1:0] many;

    assign legal = place_ok(int'(pin_i), func_i, NUM_PINS, SEL_PINS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PINS; p++) map_q[p] <= FN_NONE;
            rej_o <= 1'b0;
        end else begin
            rej_o <= we_i & ~legal;
            if (we_i && legal) begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (p == int'(pin_i)) map_q[p] <= func_i;
            end
        end
    end

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
        logic [NUM_PINS-1:0] hit;
        always_comb begin
            for (int p = 0; p < NUM_PINS; p++)
                hit[p] = (map_q[p] == FN_W'(f));
        end
        // Lowest-numbered pin wins: scan downward so it is taken last.
        always_comb begin
            route_o[f] = '0;
            if (f != 0) begin
                for (int p = NUM_PINS - 1; p >= 0; p--) begin
                    if (hit[p]) begin
                        route_o[f].present = 1'b1;
                        route_o[f].pin     = 8'(p);
                    end
                end
            end
        end
        assign many[f] = (f != 0) && ($countones(hit) > 1);
    end

    assign dup_o = |many;

    assert_reject_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && !legal) |=> rej_o);
    assert_accept_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (we_i && legal) |=> !rej_o);
endmodule

// File: rtl/ctlpin_debounce.sv
module ctlpin_debounce #(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic fire_o,
    output logic pulse_o
);
    localparam int CW = $clog2(DEB_CYC + 1);
    logic [CW-1:0] cnt_q;

    // Fires once, on the DEB_CYC-th consecutive active cycle; the count
    // then parks at DEB_CYC until the input drops.
    assign fire_o = active_i && (cnt_q == CW'(DEB_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= fire_o;
            if (!active_i)                    cnt_q <= '0;
            else if (cnt_q != CW'(DEB_CYC))   cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
    assert_pulse_after_active_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(active_i));
endmodule

// File: rtl/ctlpin_decoder.sv
module ctlpin_decoder
    import ctlpin_pkg::*;
#(
    parameter int NUM_PINS = 5,
    parameter int SEL_PINS = 3,
    parameter int NUM_OUT  = 8,
    parameter int NUM_PROF = 3,
    parameter int DEB_CYC  = 4,
    localparam int PIN_IW  = $clog2(NUM_PINS),
    localparam int PER_BANK = NUM_OUT / NUM_BANKS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                map_we,
    input  logic [PIN_IW-1:0]   map_pin,
    input  logic [FN_W-1:0]     map_func,
    output logic                map_rej_o,
    output logic                cfg_dup_o,
    output logic [NUM_OUT-1:0]  oe_o,
    output logic [1:0]          prof_o,
    output logic                rst_req_o
);
    logic [NUM_PINS-1:0]   pin_s;
    fn_route_t [NUM_FN-1:0] route;
    logic [NUM_FN-1:0]     fn_lvl;   // synchronized level of each placed function
    logic                  en_all;
    logic [NUM_BANKS-1:0]  en_bank;
    logic [1:0]            sel_code;
    logic                  rst_active;
    logic                  fire;
    logic                  armed_q;
    prof_t                 prof_q;
    logic [NUM_OUT-1:0]    oe_q;

    ctlpin_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    ctlpin_map #(
        .NUM_PINS (NUM_PINS),
        .SEL_PINS (SEL_PINS),
        .PIN_IW   (PIN_IW)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .we_i    (map_we),
        .pin_i   (map_pin),
        .func_i  (map_func),
        .rej_o   (map_rej_o),
        .dup_o   (cfg_dup_o),
        .route_o (route)
    );

    for (genvar f = 0; f < NUM_FN; f++) begin : g_lvl
        always_comb begin
            fn_lvl[f] = 1'b0;
            for (int p = 0; p < NUM_PINS; p++)
                if (route[f].present && int'(route[f].pin) == p) fn_lvl[f] = pin_s[p];
        end
    end

    // Active-low enables; an unplaced function reads as enabled.
    assign en_all = ~(route[FN_OE_ALL].present & fn_lvl[FN_OE_ALL]);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int FB = int'(FN_BANK_A) + b;
        assign en_bank[b] = ~(route[FB].present & fn_lvl[FB]);
    end

    assign sel_code   = {fn_lvl[FN_SEL1], fn_lvl[FN_SEL0]};
    assign rst_active = route[FN_DEVRST].present & ~fn_lvl[FN_DEVRST];

    ctlpin_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk      (clk),
        .rst      (rst),
        .active_i (rst_active),
        .fire_o   (fire),
        .pulse_o  (rst_req_o)
    );

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_oe
        always_ff @(posedge clk) begin
            if (rst) oe_q[o] <= 1'b1;
            else     oe_q[o] <= en_all & en_bank[o / PER_BANK];
        end
    end
    assign oe_o = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            prof_q  <= '0;
        end else begin
            armed_q <= 1'b0;
            if (armed_q || fire) prof_q <= prof_decode(sel_code, NUM_PROF);
        end
    end
    assign prof_o = prof_q;

    assert_prof_valid_R10: assert property (@(posedge clk) disable iff (rst)
        int'(prof_o) < NUM_PROF);
    assert_prof_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!fire && !armed_q) |=> $stable(prof_o));
    assert_prof_moves_with_req_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(prof_o) && !$past(armed_q)) |-> $rose(rst_req_o));
    assert_oe_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&oe_o));
endmodule

// File: tb/ctlpin_decoder_tb.sv
`timescale 1ns/1ps
module ctlpin_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] pins = 5'h1F;
    logic       map_we = 1'b0;
    logic [2:0] map_pin = '0;
    logic [3:0] map_func = '0;
    logic       map_rej_o, cfg_dup_o, rst_req_o;
    logic [7:0] oe_o;
    logic [1:0] prof_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    ctlpin_decoder u_dut (
        .clk (clk), .rst (rst), .pin_i (pins),
        .map_we (map_we), .map_pin (map_pin), .map_func (map_func),
        .map_rej_o (map_rej_o), .cfg_dup_o (cfg_dup_o),
        .oe_o (oe_o), .prof_o (prof_o), .rst_req_o (rst_req_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int pin, input int fn, output logic rej);
        @(negedge clk);
        map_we = 1'b1; map_pin = 3'(pin); map_func = 4'(fn);
        @(negedge clk);
        map_we = 1'b0;
        rej = map_rej_o;
    endtask

    // Hold the reset-function pin (pin 4) low for n cycles; return pulse
    // count and the sample index of the first pulse.
    task automatic rst_pin_low(input int n, output int pulses, output int at);
        pulses = 0; at = -1;
        pins[4] = 1'b0;
        for (int k = 1; k <= n + 8; k++) begin
            if (k == n + 1) pins[4] = 1'b1;
            @(negedge clk);
            if (rst_req_o) begin
                pulses++;
                if (at < 0) at = k;
            end
        end
    endtask

    function automatic logic [7:0] exp_oe(input logic all_lvl, input logic [3:0] bank_lvl);
        logic [7:0] e;
        for (int o = 0; o < 8; o++) e[o] = ~all_lvl & ~bank_lvl[o / 2];
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic rej;
        int   pulses, at;
        logic [7:0] e;
        logic [1:0] expp;

        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        chk(oe_o == 8'hFF, "R1 oe after reset", oe_o, 8'hFF);
        chk(prof_o == 2'd0, "R1 prof after reset", prof_o, 0);
        chk(!rst_req_o && !map_rej_o && !cfg_dup_o, "R1 flags after reset",
            {rst_req_o, map_rej_o, cfg_dup_o}, 0);
        pins = 5'h00;
        wait_n(4);
        chk(oe_o == 8'hFF, "R1 R5 empty map ignores pins", oe_o, 8'hFF);

        // R3 R4: full enable map, exhaustive pin sweep
        wr(0, 1, rej); chk(!rej, "R2 accept all-enable", rej, 0);
        for (int b = 0; b < 4; b++) begin
            wr(b + 1, 2 + b, rej);
            chk(!rej, "R2 accept bank", rej, 0);
        end
        for (int v = 0; v < 32; v++) begin
            pins = 5'(v);
            wait_n(4);
            e = exp_oe(v[0], 4'(v >> 1));
            chk(oe_o == e, "R3 R4 enable sweep", oe_o, e);
        end

        // R6 latency: pin 1 (bank A) low -> high
        pins = 5'h00; wait_n(4);
        pins[1] = 1'b1;
        wait_n(2);
        chk(oe_o[0] == 1'b1, "R6 oe unchanged after 2 edges", oe_o[0], 1);
        wait_n(1);
        chk(oe_o[0] == 1'b0, "R6 oe changed on 3rd edge", oe_o[0], 0);

        // R5: only bank B placed (pin 2)
        wr(0, 0, rej); wr(1, 0, rej); wr(3, 0, rej); wr(4, 0, rej);
        for (int v = 0; v < 32; v++) begin
            pins = 5'(v);
            wait_n(4);
            e = exp_oe(1'b0, {2'b00, v[2], 1'b0});
            chk(oe_o == e, "R5 unplaced enables read enabled", oe_o, e);
        end

        // R7 duplicate placement
        wr(2, 0, rej);
        wr(0, 1, rej); wr(2, 1, rej);
        chk(cfg_dup_o == 1'b1, "R7 dup flag set", cfg_dup_o, 1);
        pins = 5'b00100; wait_n(4);
        chk(oe_o == 8'hFF, "R7 higher pin ignored", oe_o, 8'hFF);
        pins = 5'b00001; wait_n(4);
        chk(oe_o == 8'h00, "R7 lowest pin wins", oe_o, 8'h00);
        wr(2, 0, rej);
        chk(cfg_dup_o == 1'b0, "R7 dup flag clears", cfg_dup_o, 0);

        // R2 rejected writes leave the map unchanged
        wr(3, 4, rej); chk(!rej, "R2 accept bank C on pin 3", rej, 0);
        wr(3, 6, rej); chk(rej, "R2 reject sel0 on pin 3", rej, 1);
        wr(4, 7, rej); chk(rej, "R2 reject sel1 on pin 4", rej, 1);
        wr(0, 9, rej); chk(rej, "R2 reject code 9", rej, 1);
        wr(5, 1, rej); chk(rej, "R2 reject pin 5", rej, 1);
        pins = 5'b01000; wait_n(4);
        chk(oe_o == 8'hCF, "R2 pin 3 still bank C", oe_o, 8'hCF);
        pins = 5'b01001; wait_n(4);
        chk(oe_o == 8'h00, "R2 pin 0 still all-enable", oe_o, 8'h00);

        // R8 R9 R10: profile select via reset pin
        wr(0, 6, rej); chk(!rej, "R2 accept sel0 pin 0", rej, 0);
        wr(1, 7, rej); chk(!rej, "R2 accept sel1 pin 1", rej, 0);
        wr(2, 7, rej); chk(!rej, "R2 accept sel1 pin 2", rej, 0);
        wr(2, 0, rej);
        wr(3, 0, rej);
        wr(4, 8, rej); chk(!rej, "R2 accept reset pin 4", rej, 0);
        for (int c = 0; c < 4; c++) begin
            pins = {1'b1, 2'b00, 2'(c)};
            wait_n(4);
            rst_pin_low(6, pulses, at);
            chk(pulses == 1, "R8 one pulse", pulses, 1);
            chk(at == 6, "R8 pulse on sixth edge", at, 6);
            expp = (c == 3) ? 2'd0 : 2'(c);
            chk(prof_o == expp, "R9 R10 profile latched", prof_o, expp);
        end
        pins = 5'b10010; wait_n(8);
        chk(prof_o == 2'd0, "R9 select change without reset ignored", prof_o, 0);
        rst_pin_low(3, pulses, at);
        chk(pulses == 0, "R8 3-cycle low no pulse", pulses, 0);
        chk(prof_o == 2'd0, "R9 no latch without pulse", prof_o, 0);
        rst_pin_low(4, pulses, at);
        chk(pulses == 1, "R8 4-cycle low one pulse", pulses, 1);
        chk(prof_o == 2'd2, "R9 latched code 2", prof_o, 2);
        pins = 5'b10001; wait_n(4);
        rst_pin_low(12, pulses, at);
        chk(pulses == 1, "R8 long low single pulse", pulses, 1);
        chk(prof_o == 2'd1, "R9 latched code 1", prof_o, 1);

        // R1 R9: power-up latch clears map, profile back to 0
        rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(2);
        chk(prof_o == 2'd0, "R1 R9 profile after reset", prof_o, 0);
        pins = 5'b00000; wait_n(8);
        chk(!rst_req_o && oe_o == 8'hFF, "R1 map cleared by reset", oe_o, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule